// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block produces the timing skeleton of one SPI master frame from the system clock. A frame engine requests a frame. The timer then runs three phases in turn. First it counts the delay from chip-select assertion to the first serial-clock edge. Next it produces serial-clock periods for as long as the engine wants them. Last it counts the delay from the final serial-clock edge to chip-select negation. The engine uses the strobes to drive chip-select and the shift path. It uses `sck_level` as the unpolarised serial clock.

Each interval is set by a two-stage divider. The serial-clock period is a prescaler from {2,3,5,7} multiplied by a scaler taken from a 16-entry table. The two chip-select delays each have their own prescaler from {1,3,5,7} and their own power-of-two scaler. All six field inputs are captured when a frame starts and held for the whole frame. A new setting therefore only takes effect at the next frame boundary.

Top module: `spi_sck_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `sck_level`, `lead_done`, `sck_rise`, `sck_fall` and `trail_done` are all 0.
- R2: A `frame_start` sampled while idle begins the lead delay. The lead delay lasts Pd×2^(n+1) cycles, where Pd is chosen by `lead_pre` (0→1, 1→3, 2→5, 3→7) and n is `lead_scl`. `lead_done` is high for exactly one cycle, the last cycle of the delay.
- R3: The serial-clock period is Pb×Sb cycles. Pb is chosen by `baud_pre` (0→2, 1→3, 2→5, 3→7). Sb is chosen by `baud_scl` (0→2, 1→4, 2→6, 3→8, k≥4→2^k). `sck_level` is high for the first half of each period and low for the second half. The first period starts in the cycle right after `lead_done`.
- R4: `sck_rise` is high for exactly the first cycle in which `sck_level` is high in a period. `sck_fall` is high for exactly the first cycle in which it is low.
- R5: `last_period` is sampled in the final cycle of each period. If it is high, the clock phase ends. If it is low, a new period begins at once.
- R6: The trail delay follows the last period immediately. It uses the same encoding as R2 with `trail_pre` and `trail_scl`. `trail_done` is high during its last cycle.
- R7: `busy` is high from the cycle after an accepted `frame_start` through the `trail_done` cycle, and low in the next cycle.
- R8: `frame_start` has no effect while `busy` is high, including in the `trail_done` cycle.
- R9: Changes to any field input after the start cycle do not affect the running frame.
- R10: At most one of `lead_done`, `sck_rise`, `sck_fall`, `trail_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Request a new frame (accepted only when idle) |
| last_period | input | 1 | End the clock phase after the current period |
| baud_pre | input | 2 | Serial-clock prescaler select |
| baud_scl | input | 4 | Serial-clock scaler select |
| lead_pre | input | 2 | Lead-delay prescaler select |
| lead_scl | input | 4 | Lead-delay scaler exponent |
| trail_pre | input | 2 | Trail-delay prescaler select |
| trail_scl | input | 4 | Trail-delay scaler exponent |
| busy | output | 1 | Frame in progress |
| lead_done | output | 1 | Last cycle of the lead delay |
| sck_rise | output | 1 | Serial clock enters its high half |
| sck_fall | output | 1 | Serial clock enters its low half |
| sck_level | output | 1 | Unpolarised serial-clock level |
| trail_done | output | 1 | Last cycle of the trail delay |

## Verification
Two cases are provoked on purpose. In the first, a new frame request arrives in the very cycle that the trail delay completes. The bench raises `frame_start` during the `trail_done` cycle and checks that `busy` falls in the next cycle, with no lead delay following. In the second, field changes and a repeated start collide with an active frame. The bench rewrites every field and pulses `frame_start` in the first lead cycle. It then confirms that the frame length, the lead length and the clock-edge count all match the values that were captured at the start. A behavioural phase model compares every output on every cycle.

// File: rtl/spi_tmr_pkg.sv
// Shared types and divider decode functions for the SPI clock/delay timer.
// Assumes field encodings as documented in the brief; all results fit in 20 bits.
package spi_tmr_pkg;

    localparam int TMR_CNT_W = 20;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_SCK   = 2'd2,
        PH_TRAIL = 2'd3
    } tmr_phase_e;

    // Serial-clock divide ratio: prescaler {2,3,5,7} times scaler table.
    function automatic int unsigned baud_ratio(input logic [1:0] pre, input logic [3:0] scl);
        int unsigned p;
        int unsigned s;
        case (pre)
            2'd0:    p = 2;
            2'd1:    p = 3;
            2'd2:    p = 5;
            default: p = 7;
        endcase
        if (scl < 4'd4) s = 2 * (int'(scl) + 1);
        else            s = 1 << scl;
        return p * s;
    endfunction

    // Chip-select delay: prescaler {1,3,5,7} times 2^(n+1).
    function automatic int unsigned delay_len(input logic [1:0] pre, input logic [3:0] scl);
        int unsigned p;
        case (pre)
            2'd0:    p = 1;
            2'd1:    p = 3;
            2'd2:    p = 5;
            default: p = 7;
        endcase
        return p * (2 << scl);
    endfunction

endpackage

// File: rtl/spi_tmr_shadow.sv
// Captures one prescaler/scaler field pair at frame start and decodes it to a
// length in system clocks. IS_BAUD selects the serial-clock decode, else the
// chip-select delay decode. Assumes load is a single-cycle strobe.
module spi_tmr_shadow #(
    parameter int CNT_W   = spi_tmr_pkg::TMR_CNT_W,
    parameter bit IS_BAUD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       fld_pre,
    input  logic [3:0]       fld_scl,
    output logic [CNT_W-1:0] len
);
    logic [1:0] pre_q;
    logic [3:0] scl_q;

    // Hold the field pair stable for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            scl_q <= '0;
        end else if (load) begin
            pre_q <= fld_pre;
            scl_q <= fld_scl;
        end
    end

    generate
        if (IS_BAUD) begin : g_baud
            // Decode the serial-clock period length.
            always_comb len = CNT_W'(spi_tmr_pkg::baud_ratio(pre_q, scl_q));
        end else begin : g_delay
            // Decode the chip-select delay length.
            always_comb len = CNT_W'(spi_tmr_pkg::delay_len(pre_q, scl_q));
        end
    endgenerate
endmodule

// File: rtl/spi_tmr_count.sv
// Shared interval counter: clears to zero on request, otherwise counts up, and
// flags the last cycle of an interval of length 'limit'. Assumes limit >= 2.
module spi_tmr_count #(
    parameter int CNT_W = spi_tmr_pkg::TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);
    // Count cycles within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    // Terminal-cycle compare.
    always_comb at_end = (cnt == limit - 1'b1);
endmodule

// File: rtl/spi_tmr_seq.sv
// Phase sequencer: idle -> lead delay -> clock periods -> trail delay -> idle.
// Selects the interval limit for the counter and derives all strobes from the
// phase and count. Assumes the period length is even (true for every encoding).
module spi_tmr_seq #(
    parameter int CNT_W = spi_tmr_pkg::TMR_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             last_period,
    input  logic [CNT_W-1:0] cnt,
    input  logic             at_end,
    input  logic [CNT_W-1:0] lead_len,
    input  logic [CNT_W-1:0] ratio,
    input  logic [CNT_W-1:0] trail_len,
    output logic             load,
    output logic             clr,
    output logic [CNT_W-1:0] limit,
    output logic             busy,
    output logic             lead_done,
    output logic             sck_rise,
    output logic             sck_fall,
    output logic             sck_level,
    output logic             trail_done
);
    import spi_tmr_pkg::*;

    tmr_phase_e       phase_q, phase_d;
    logic [CNT_W-1:0] half;

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (frame_start) phase_d = PH_LEAD;
            PH_LEAD:  if (at_end) phase_d = PH_SCK;
            PH_SCK:   if (at_end && last_period) phase_d = PH_TRAIL;
            PH_TRAIL: if (at_end) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Interval length for the active phase.
    always_comb begin
        case (phase_q)
            PH_SCK:   limit = ratio;
            PH_TRAIL: limit = trail_len;
            default:  limit = lead_len;
        endcase
    end

    // Counter control and field capture.
    always_comb begin
        load = (phase_q == PH_IDLE) && frame_start;
        clr  = (phase_q == PH_IDLE) || at_end;
        half = ratio >> 1;
    end

    // Output strobes and levels.
    always_comb begin
        busy       = (phase_q != PH_IDLE);
        lead_done  = (phase_q == PH_LEAD)  && at_end;
        trail_done = (phase_q == PH_TRAIL) && at_end;
        sck_rise   = (phase_q == PH_SCK)   && (cnt == '0);
        sck_fall   = (phase_q == PH_SCK)   && (cnt == half);
        sck_level  = (phase_q == PH_SCK)   && (cnt < half);
    end
endmodule

// File: rtl/spi_sck_timer.sv
// Top of the SPI serial-clock and chip-select delay timer. Three field shadows
// (lead, baud, trail) feed one shared counter driven by the phase sequencer.
// Assumes a single frame engine that drives frame_start and last_period.
module spi_sck_timer #(
    parameter int CNT_W = spi_tmr_pkg::TMR_CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       last_period,
    input  logic [1:0] baud_pre,
    input  logic [3:0] baud_scl,
    input  logic [1:0] lead_pre,
    input  logic [3:0] lead_scl,
    input  logic [1:0] trail_pre,
    input  logic [3:0] trail_scl,
    output logic       busy,
    output logic       lead_done,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic       sck_level,
    output logic       trail_done
);
    localparam int NUM_FLD = 3;

    logic             load;
    logic             clr;
    logic             at_end;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [1:0]       fld_pre [NUM_FLD];
    logic [3:0]       fld_scl [NUM_FLD];
    logic [CNT_W-1:0] fld_len [NUM_FLD];

    // Field order: 0 lead delay, 1 serial clock, 2 trail delay.
    always_comb begin
        fld_pre[0] = lead_pre;  fld_scl[0] = lead_scl;
        fld_pre[1] = baud_pre;  fld_scl[1] = baud_scl;
        fld_pre[2] = trail_pre; fld_scl[2] = trail_scl;
    end

    generate
        for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
            spi_tmr_shadow #(
                .CNT_W  (CNT_W),
                .IS_BAUD(g == 1)
            ) u_shadow (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (load),
                .fld_pre(fld_pre[g]),
                .fld_scl(fld_scl[g]),
                .len    (fld_len[g])
            );
        end
    endgenerate

    spi_tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .limit (limit),
        .cnt   (cnt),
        .at_end(at_end)
    );

    spi_tmr_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .last_period(last_period),
        .cnt        (cnt),
        .at_end     (at_end),
        .lead_len   (fld_len[0]),
        .ratio      (fld_len[1]),
        .trail_len  (fld_len[2]),
        .load       (load),
        .clr        (clr),
        .limit      (limit),
        .busy       (busy),
        .lead_done  (lead_done),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .sck_level  (sck_level),
        .trail_done (trail_done)
    );
endmodule

// File: rtl/spi_tmr_checker.sv
// Port-level temporal checks for spi_sck_timer, attached by bind.
module spi_tmr_checker (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic busy,
    input logic lead_done,
    input logic sck_rise,
    input logic sck_fall,
    input logic sck_level,
    input logic trail_done
);
    assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_done, sck_rise, sck_fall, trail_done}));

    assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |-> (sck_level && !$past(sck_level)));

    assert_fall_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fall |-> (!sck_level && $past(sck_level)));

    assert_first_edge_after_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lead_done |=> sck_rise);

    assert_idle_after_trail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_done |=> !busy);

    assert_start_accepted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frame_start) |=> busy);

    assert_clock_inside_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sck_level |-> busy);

    assert_no_restart_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_done && frame_start) |=> (!busy && !lead_done));
endmodule

bind spi_sck_timer spi_tmr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .busy       (busy),
    .lead_done  (lead_done),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .sck_level  (sck_level),
    .trail_done (trail_done)
);

// File: tb/spi_sck_timer_bench.sv
// Self-checking bench: behavioural phase model compared on every clock, plus
// directed frame-length checks.
module spi_sck_timer_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       last_period = 1'b0;
    logic [1:0] baud_pre = '0, lead_pre = '0, trail_pre = '0;
    logic [3:0] baud_scl = '0, lead_scl = '0, trail_scl = '0;
    logic       busy, lead_done, sck_rise, sck_fall, sck_level, trail_done;

    spi_sck_timer u_spi_sck_timer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .last_period(last_period),
        .baud_pre(baud_pre), .baud_scl(baud_scl), .lead_pre(lead_pre), .lead_scl(lead_scl),
        .trail_pre(trail_pre), .trail_scl(trail_scl), .busy(busy), .lead_done(lead_done),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sck_level(sck_level), .trail_done(trail_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit seen_edge = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic int m_baud(input int p, input int s);
        int pt[4] = '{2, 3, 5, 7};
        return pt[p] * ((s < 4) ? 2 * (s + 1) : (1 << s));
    endfunction

    function automatic int m_dly(input int p, input int s);
        int pt[4] = '{1, 3, 5, 7};
        return pt[p] * (2 << s);
    endfunction

    // Reference model: phase 0 idle, 1 lead, 2 clock, 3 trail.
    int mph = 0, mcnt = 0, ml = 2, mr = 4, mt = 2;

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (!rst_n) begin
            mph = 0; mcnt = 0;
        end else begin
            case (mph)
                0: if (frame_start) begin
                       ml = m_dly(lead_pre, lead_scl);
                       mr = m_baud(baud_pre, baud_scl);
                       mt = m_dly(trail_pre, trail_scl);
                       mph = 1; mcnt = 0;
                   end
                1: if (mcnt == ml - 1) begin mph = 2; mcnt = 0; end else mcnt++;
                2: if (mcnt == mr - 1) begin
                       mcnt = 0;
                       if (last_period) mph = 3;
                   end else mcnt++;
                default: if (mcnt == mt - 1) begin mph = 0; mcnt = 0; end else mcnt++;
            endcase
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (seen_edge) begin
            chk("R7",  "busy",       busy,       mph != 0);
            chk("R2",  "lead_done",  lead_done,  mph == 1 && mcnt == ml - 1);
            chk("R4",  "sck_rise",   sck_rise,   mph == 2 && mcnt == 0);
            chk("R4",  "sck_fall",   sck_fall,   mph == 2 && mcnt == mr / 2);
            chk("R3",  "sck_level",  sck_level,  mph == 2 && mcnt < mr / 2);
            chk("R6",  "trail_done", trail_done, mph == 3 && mcnt == mt - 1);
            chk("R10", "strobe count", 32'(lead_done) + 32'(sck_rise) + 32'(sck_fall) + 32'(trail_done),
                (32'(lead_done) + 32'(sck_rise) + 32'(sck_fall) + 32'(trail_done)) <= 1 ?
                32'(lead_done) + 32'(sck_rise) + 32'(sck_fall) + 32'(trail_done) : 1);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL R7 watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // One frame of nper clock periods; optional disturbance (R9, R8) and a
    // start request in the trail_done cycle (R8).
    task automatic frame(input int bp, bs, lp, ls, tp, ts, nper, input bit scramble, input bit restart);
        int len = 0, rises = 0, lead_seen = 0;
        int exp_len = m_dly(lp, ls) + nper * m_baud(bp, bs) + m_dly(tp, ts);
        bit hit_end = 0;
        @(negedge clk);
        baud_pre = 2'(bp); baud_scl = 4'(bs);
        lead_pre = 2'(lp); lead_scl = 4'(ls);
        trail_pre = 2'(tp); trail_scl = 4'(ts);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = scramble;
        if (scramble) begin
            baud_pre = 2'(bp ^ 3); baud_scl = 4'(bs ^ 5);
            lead_pre = 2'(lp ^ 2); lead_scl = 4'(ls ^ 3);
            trail_pre = 2'(tp ^ 1); trail_scl = 4'(ts ^ 6);
        end
        while (busy && len < 60000) begin
            if (sck_rise) rises++;
            last_period = (rises >= nper);  // R5: end after the nper-th period
            len++;
            if (lead_done) lead_seen = len;
            if (trail_done && restart) begin frame_start = 1'b1; hit_end = 1; end
            @(negedge clk);
            frame_start = 1'b0;
        end
        last_period = 1'b0;
        if (hit_end) chk("R8", "busy after start in trail_done cycle", busy, 0);
        if (scramble) chk("R9", "frame length with fields changed", len, exp_len);
        else          chk("R6", "frame length", len, exp_len);
        chk("R2", "lead length", lead_seen, m_dly(lp, ls));
        chk("R5", "periods produced", rises, nper);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "sck_level in reset", sck_level, 0);
        chk("R1", "strobes in reset", {lead_done, sck_rise, sck_fall, trail_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        frame(0, 0, 0, 0, 0, 0, 2, 0, 0);   // shortest intervals
        frame(1, 2, 2, 1, 3, 0, 3, 0, 0);   // ratio 18, lead 20, trail 14
        frame(3, 4, 1, 3, 2, 2, 1, 0, 0);   // ratio 112
        frame(2, 3, 3, 0, 0, 1, 2, 1, 0);   // fields disturbed mid-frame
        frame(0, 1, 0, 2, 1, 1, 1, 0, 1);   // start during trail_done
        frame(0, 9, 0, 10, 0, 0, 1, 0, 0);  // ratio 1024, lead 2048
        frame(1, 0, 3, 1, 3, 3, 4, 1, 1);   // both disturbances
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule